// File: doc/BRIEF.md
# PHY Test-Register Serial Port

This block models the byte-wide test and configuration port of a display PHY, together with the host-side bit-bang master that drives it. The port has four inputs: a test clock, a test enable, a test clear, and an 8-bit data-in bus. It also has an 8-bit data-out bus. Address and data share the data-in bus. The level of the enable at each falling test-clock edge decides the phase: with enable high the bus is taken as a register address, and with enable low it is written into the addressed register. The registers behind the port are plain byte storage.

Software reaches the port through two 32-bit control words. Control word 0 carries the clear and clock levels. Control word 1 carries the data-in byte and the enable, and returns the data-out byte. A write follows this sequence:

1. Raise enable with the address on data-in.
2. Pulse the clock.
3. Lower enable with the value on data-in.
4. Pulse the clock again.

A read stops after the address pulse and takes data-out back through control word 1. Initialisation pulses clear low, high, then low.

Top module: `phy_tport`

## Requirements
- R1: After rst_ni is released, both control words read zero, all port pins are low, and data-out is zero.
- R2: Control word 0 (select 0): bit 0 drives the test clear, bit 1 drives the test clock. Both read back unchanged, and all other bits read zero.
- R3: Control word 1 (select 1): bits 7:0 drive data-in and bit 16 drives the enable. Both read back. Bits 15:8 are read-only, and a write to them has no effect.
- R4: A falling test-clock edge while enable is high latches data-in as the register address.
- R5: A falling test-clock edge while enable is low writes data-in into the register at the latched address.
- R6: A rising test-clock edge changes neither the latched address nor any register.
- R7: Data-out always shows the register at the latched address. After a data write it shows the new value.
- R8: While the test clear is high, every register and the address latch are zero, and clock edges have no effect. The clear acts without waiting for a clock edge.
- R9: Bits 15:8 of control word 1 read the current data-out byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_sel_i | input | 1 | Control word select (0 or 1) |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Selected control word read data |
| tst_clk_o | output | 1 | Test clock pin |
| tst_en_o | output | 1 | Test enable pin |
| tst_clr_o | output | 1 | Test clear pin |
| tst_din_o | output | 8 | Test data-in pin |
| tst_dout_o | output | 8 | Test data-out pin |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- Rising clock edges placed between the phases. A port that latched on the wrong edge would pick up a half-set-up address or value.
- Reads straight after writes to the same and to different addresses. A data-out that did not follow the latched register, or that lagged a write, would return stale bytes.
- Clock pulses issued while clear is held high. A clear that was only a one-shot, or that let edges through, would leave non-zero storage after clear drops.
- Writes aimed at the read-only data-out field. A master that stored those bits would corrupt the read path.

// File: rtl/phy_tport_pkg.sv
package phy_tport_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CLR_BIT  = 0;
  localparam int unsigned CLK_BIT  = 1;
  localparam int unsigned DIN_LSB  = 0;
  localparam int unsigned DOUT_LSB = 8;
  localparam int unsigned EN_BIT   = 16;
endpackage

// File: rtl/phy_tport_master.sv
module phy_tport_master
  import phy_tport_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] dout_i,
  output logic              tclk_o,
  output logic              tclr_o,
  output logic              ten_o,
  output logic [DATA_W-1:0] tdin_o
);
  logic              clk_q, clr_q, en_q;
  logic [DATA_W-1:0] din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= 1'b0;
      clr_q <= 1'b0;
      en_q  <= 1'b0;
      din_q <= '0;
    end else if (we_i) begin
      if (!sel_i) begin
        clr_q <= wdata_i[CLR_BIT];
        clk_q <= wdata_i[CLK_BIT];
      end else begin
        din_q <= wdata_i[DIN_LSB +: DATA_W];
        en_q  <= wdata_i[EN_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!sel_i) begin
      rdata_o[CLR_BIT] = clr_q;
      rdata_o[CLK_BIT] = clk_q;
    end else begin
      rdata_o[DIN_LSB +: DATA_W]  = din_q;
      rdata_o[DOUT_LSB +: DATA_W] = dout_i;
      rdata_o[EN_BIT]             = en_q;
    end
  end

  assign tclk_o = clk_q;
  assign tclr_o = clr_q;
  assign ten_o  = en_q;
  assign tdin_o = din_q;
endmodule

// File: rtl/phy_tport_slave.sv
module phy_tport_slave #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tclk_i,
  input  logic              tclr_i,
  input  logic              ten_i,
  input  logic [DATA_W-1:0] tdin_i,
  output logic [DATA_W-1:0] tdout_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned NREG = 1 << ADDR_W;

  logic              tclk_d;
  logic              fall;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tclk_d <= 1'b0;
    else         tclk_d <= tclk_i;
  end

  assign fall = tclk_d & ~tclk_i;

  always_ff @(posedge clk_i or negedge rst_ni or posedge tclr_i) begin
    if (!rst_ni)               addr_q <= '0;
    else if (tclr_i)           addr_q <= '0;
    else if (fall && ten_i)    addr_q <= tdin_i[ADDR_W-1:0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni or posedge tclr_i) begin
      if (!rst_ni)      mem[g] <= '0;
      else if (tclr_i)  mem[g] <= '0;
      else if (fall && !ten_i && addr_q == ADDR_W'(g)) mem[g] <= tdin_i;
    end
  end

  assign tdout_o = mem[addr_q];
  assign addr_o  = addr_q;
endmodule

// File: rtl/phy_tport.sv
module phy_tport
  import phy_tport_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_sel_i,
  input  logic              reg_we_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              tst_clk_o,
  output logic              tst_en_o,
  output logic              tst_clr_o,
  output logic [DATA_W-1:0] tst_din_o,
  output logic [DATA_W-1:0] tst_dout_o
);
  logic [ADDR_W-1:0] tst_addr;

  phy_tport_master #(.DATA_W(DATA_W)) u_master (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (reg_sel_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .dout_i  (tst_dout_o),
    .tclk_o  (tst_clk_o),
    .tclr_o  (tst_clr_o),
    .ten_o   (tst_en_o),
    .tdin_o  (tst_din_o)
  );

  phy_tport_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slave (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tclk_i  (tst_clk_o),
    .tclr_i  (tst_clr_o),
    .ten_i   (tst_en_o),
    .tdin_i  (tst_din_o),
    .tdout_o (tst_dout_o),
    .addr_o  (tst_addr)
  );
endmodule

// File: rtl/phy_tport_chk.sv
module phy_tport_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tclk,
  input logic              tclr,
  input logic              ten,
  input logic [DATA_W-1:0] tdin,
  input logic [DATA_W-1:0] tdout,
  input logic [ADDR_W-1:0] taddr
);
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tclr |-> (taddr == '0 && tdout == '0)); // R8

  AST_ADDR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tclk) && !tclk && ten && !tclr) |=> (tclr || taddr == $past(tdin[ADDR_W-1:0]))); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tclr && !($past(tclk) && !tclk)) |=> (tclr || $stable(taddr))); // R6

  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tclr && !($past(tclk) && !tclk)) |=> (tclr || $stable(tdout))); // R7
endmodule

bind phy_tport phy_tport_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tclk  (tst_clk_o),
  .tclr  (tst_clr_o),
  .ten   (tst_en_o),
  .tdin  (tst_din_o),
  .tdout (tst_dout_o),
  .taddr (tst_addr)
);

// File: tb/phy_tport_bench.sv
module phy_tport_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tst_clk_o, tst_en_o, tst_clr_o;
  logic [7:0]  tst_din_o, tst_dout_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] model [256];
  logic [7:0] cur_addr;

  always #4 clk_i = ~clk_i;

  phy_tport u_phy_tport (
    .clk_i, .rst_ni, .reg_sel_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .tst_clk_o, .tst_en_o, .tst_clr_o, .tst_din_o, .tst_dout_o
  );

  function automatic logic [31:0] ctl1(logic en, logic [7:0] din);
    return {15'd0, en, 8'd0, din};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk_i);
    reg_sel_i = sel; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    @(negedge clk_i);
    reg_sel_i = sel;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse();
    wr(1'b0, 32'h2);
    wr(1'b0, 32'h0);
  endtask

  task automatic phy_wr(logic [7:0] a, logic [7:0] v);
    wr(1'b1, ctl1(1'b1, a)); pulse();
    wr(1'b1, ctl1(1'b0, v)); pulse();
    cur_addr = a; model[a] = v;
  endtask

  task automatic phy_rd(logic [7:0] a, output logic [7:0] v);
    logic [31:0] r;
    wr(1'b1, ctl1(1'b1, a)); pulse();
    wr(1'b1, ctl1(1'b0, a));
    cur_addr = a;
    rd(1'b1, r);
    v = r[15:8];
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  v;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    cur_addr = 8'h00;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    rd(1'b0, r); check("R1 ctl0", r, 32'h0);
    rd(1'b1, r); check("R1 ctl1", r, 32'h0);
    check("R1 pins", {tst_clk_o, tst_en_o, tst_clr_o, tst_din_o, tst_dout_o}, '0);

    // init sequence: clear low, high, low
    wr(1'b0, 32'h0); wr(1'b0, 32'h1);
    check("R2 clr pin", {31'd0, tst_clr_o}, 32'h1);
    rd(1'b0, r); check("R2 ctl0 clr readback", r, 32'h1);
    wr(1'b0, 32'h0);
    wr(1'b0, 32'hFFFF_FFFE);
    rd(1'b0, r); check("R2 ctl0 clk readback, other bits zero", r, 32'h2);
    check("R2 clk pin", {31'd0, tst_clk_o}, 32'h1);
    wr(1'b0, 32'h0);

    wr(1'b1, ctl1(1'b1, 8'h5A));
    rd(1'b1, r); check("R3 ctl1 readback", r & 32'hFFFF_00FF, 32'h0001_005A);
    check("R3 pins", {23'd0, tst_en_o, tst_din_o}, 32'h15A);
    // latches addr 0x5A (all regs zero)
    pulse(); cur_addr = 8'h5A;

    phy_wr(8'h10, 8'hC3);
    check("R5 dout after write", {24'd0, tst_dout_o}, 32'hC3);
    rd(1'b1, r); check("R9 ctl1 dout field", {24'd0, r[15:8]}, 32'hC3);

    // R3: write to read-only dout field ignored
    wr(1'b1, 32'h0000_AA10);
    rd(1'b1, r); check("R3 dout field read-only", {24'd0, r[15:8]}, 32'hC3);

    // R6: rising edge with en low and new din must not write
    wr(1'b1, ctl1(1'b0, 8'h77));
    wr(1'b0, 32'h2);
    check("R6 rising edge no write", {24'd0, tst_dout_o}, 32'hC3);
    wr(1'b0, 32'h0); model[8'h10] = 8'h77;
    check("R5 falling edge writes", {24'd0, tst_dout_o}, 32'h77);

    // R6: rising edge with en high must not relatch
    wr(1'b1, ctl1(1'b1, 8'h22));
    wr(1'b0, 32'h2);
    check("R6 rising edge no latch", {24'd0, tst_dout_o}, 32'h77);
    wr(1'b0, 32'h0); cur_addr = 8'h22;
    check("R4 address latched", {24'd0, tst_dout_o}, 32'h00);

    phy_wr(8'hFF, 8'h81); phy_wr(8'h00, 8'h18);
    phy_rd(8'hFF, v); check("R7 read top address", {24'd0, v}, 32'h81);
    phy_rd(8'h00, v); check("R7 read address zero", {24'd0, v}, 32'h18);

    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [7:0] a, d;
      a = 8'($urandom_range(0, 15));
      d = 8'($urandom);
      if ($urandom_range(0, 1) == 0) phy_wr(a, d);
      else begin
        phy_rd(a, v);
        check("R7 random read", {24'd0, v}, {24'd0, model[a]});
      end
    end

    // R8: clear with pulses while high
    phy_wr(8'h03, 8'h3C);
    wr(1'b0, 32'h1);
    check("R8 dout zero under clear", {24'd0, tst_dout_o}, 32'h0);
    wr(1'b1, ctl1(1'b1, 8'h03));
    wr(1'b0, 32'h3); wr(1'b0, 32'h1);
    wr(1'b1, ctl1(1'b0, 8'h99));
    wr(1'b0, 32'h3); wr(1'b0, 32'h1);
    check("R8 edges ignored under clear", {24'd0, tst_dout_o}, 32'h0);
    wr(1'b0, 32'h0);
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    check("R8 addr zero after clear", {24'd0, tst_dout_o}, {24'd0, model[0]});
    phy_rd(8'h03, v); check("R8 reg cleared", {24'd0, v}, 32'h0);
    phy_rd(8'h10, v); check("R8 reg cleared 2", {24'd0, v}, 32'h0);
    phy_wr(8'h03, 8'h5E);
    phy_rd(8'h03, v); check("R5 write after clear", {24'd0, v}, 32'h5E);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule